// File: doc/BRIEF.md
# Fractional Serial Baud Rate Generator

This block makes the timing ticks for a serial port. It divides the input clock by a 16-bit integer divisor plus an optional fraction in eighths of a clock. From that division it produces an oversampling clock, as a level and as a one-cycle tick, and a one-cycle bit-rate tick. The number of oversampling periods per bit depends on the line mode. Asynchronous framing uses 16 or 8 periods per bit. Synchronous and SPI framing use one period per bit. Smart-card framing uses as many periods as the 11-bit FI/DI ratio input gives.

Software sets the divisor and the fraction through one 32-bit register on a simple write port. A protect input blocks writes while it is high. A new setting is sampled only when a period ends, so no clock phase is ever cut short.

The oversampling divider is a three-state machine:
- OS_OFF is idle, with the divisor at zero.
- OS_HIGH is the high phase. It lasts cd − ⌊cd/2⌋ clocks, plus one clock when the fraction accumulator carries.
- OS_LOW is the low phase. It lasts ⌊cd/2⌋ clocks.

Its transitions are:
- OFF→HIGH: start, once the divisor is nonzero.
- HIGH→LOW: the high phase is done.
- HIGH→HIGH or LOW→HIGH: reload at the period boundary.
- any state→OFF: the divisor is seen at zero at a boundary.

The bit-rate divider has two states:
- RT_IDLE holds while the divider is stopped or the ratio is zero. It moves to RT_COUNT when both are valid.
- RT_COUNT counts oversampling ticks and wraps. It returns to RT_IDLE when either condition is lost.

Top module: `frac_baud_gen`

## Requirements
- R1: The register holds the divisor cd in bits 15:0 and the fraction fp in bits 18:16. All other bits read as zero. After reset the register reads 0, and os_tick, os_clk and bit_tick are low.
- R2: A write made while wr_prot is high changes neither the readback nor the tick timing.
- R3: With cd = 0, no os_tick and no bit_tick is produced, and os_clk stays low.
- R4: Each oversampling period lasts cd or cd+1 clocks. Any 8 consecutive periods with the same setting span exactly 8·cd + fp clocks.
- R5: os_tick is high in the first clock of each high phase. The high phase lasts cd − ⌊cd/2⌋ clocks, plus one clock on an accumulator carry. The low phase lasts ⌊cd/2⌋ clocks.
- R6: A new cd/fp is sampled only at a period boundary. A write captured on the boundary edge itself takes effect one period later.
- R7: With line_mode = 2'b00 (asynchronous), bit_tick comes on every 16th os_tick when over_sel = 0, and on every 8th when over_sel = 1.
- R8: With line_mode = 2'b01 (synchronous) or 2'b10 (SPI), bit_tick comes with every os_tick.
- R9: With line_mode = 2'b11 (smart card), bit_tick comes on every fidi_ratio-th os_tick. A ratio of 0 produces no bit_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (selected) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_prot | input | 1 | Write protect; blocks writes when high |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register readback |
| line_mode | input | 2 | 00 async, 01 sync, 10 SPI, 11 smart card |
| over_sel | input | 1 | Async oversampling: 0 = 16x, 1 = 8x |
| fidi_ratio | input | 11 | Smart-card FI/DI ratio; 0 disables bit ticks |
| os_tick | output | 1 | One-cycle pulse at each oversampling period start |
| os_clk | output | 1 | Oversampling clock level |
| bit_tick | output | 1 | One-cycle pulse once per bit |

## Verification
Two events can fall on the same clock edge: a register write and the period boundary at which the divider reloads its setting. The bench times a divisor write so that it is captured exactly on the boundary edge, and in a second run one edge earlier. The tick spacings that follow are then compared with the rule that the boundary edge still reloads the old value. The later write must therefore show one more old-length period than the earlier one.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int CD_W   = 16;
    localparam int FP_W   = 3;
    localparam int FIDI_W = 11;
    localparam int REG_W  = 32;
    localparam int FP_LSB = 16;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_SYNC  = 2'b01,
        MODE_SPI   = 2'b10,
        MODE_CARD  = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        OS_OFF  = 2'b00,
        OS_HIGH = 2'b01,
        OS_LOW  = 2'b10
    } os_state_e;

    typedef enum logic {
        RT_IDLE  = 1'b0,
        RT_COUNT = 1'b1
    } rt_state_e;
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg #(
    parameter int CD_W   = 16,
    parameter int FP_W   = 3,
    parameter int FP_LSB = 16,
    parameter int REG_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_prot,
    input  logic [REG_W-1:0] wr_data,
    output logic [CD_W-1:0]  cfg_cd,
    output logic [FP_W-1:0]  cfg_fp,
    output logic [REG_W-1:0] rd_data
);
    logic accept;

    assign accept = wr_en && !wr_prot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_cd <= '0;
            cfg_fp <= '0;
        end else if (accept) begin
            cfg_cd <= wr_data[CD_W-1:0];
            cfg_fp <= wr_data[FP_LSB +: FP_W];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[CD_W-1:0]       = cfg_cd;
        rd_data[FP_LSB +: FP_W] = cfg_fp;
    end

    // R2: protected writes leave the register untouched
    a_r2_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_prot) |=> $stable(rd_data));
endmodule

// File: rtl/fbg_frac_div.sv
module fbg_frac_div
    import fbg_pkg::*;
#(
    parameter int CD_W = 16,
    parameter int FP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] cfg_cd,
    input  logic [FP_W-1:0] cfg_fp,
    output logic            os_tick,
    output logic            os_clk,
    output logic            running
);
    os_state_e       state, nxt_state;
    logic [CD_W-1:0] cnt, nxt_cnt;
    logic [CD_W-1:0] low_len, nxt_low_len;
    logic [FP_W-1:0] acc, nxt_acc;
    logic            first, nxt_first;

    logic [FP_W:0]   sum;
    logic            carry;
    logic [CD_W-1:0] half;
    logic [CD_W-1:0] hi_len;
    logic            period_end;

    // Load values for the next period, taken from the live register
    always_comb begin
        sum    = {1'b0, acc} + {1'b0, cfg_fp};
        carry  = sum[FP_W];
        half   = cfg_cd >> 1;
        hi_len = cfg_cd - half + CD_W'(carry);
    end

    // Next-state logic
    always_comb begin
        nxt_state   = state;
        nxt_cnt     = cnt;
        nxt_low_len = low_len;
        nxt_acc     = acc;
        nxt_first   = 1'b0;
        period_end  = 1'b0;
        unique case (state)
            OS_OFF: begin
                period_end = 1'b1;
            end
            OS_HIGH: begin
                if (cnt == '0) begin
                    if (low_len == '0) begin
                        period_end = 1'b1;
                    end else begin
                        nxt_state = OS_LOW;
                        nxt_cnt   = low_len - 1'b1;
                    end
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            OS_LOW: begin
                if (cnt == '0) begin
                    period_end = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            default: begin
                nxt_state = OS_OFF;
            end
        endcase
        if (period_end) begin
            if (cfg_cd == '0) begin
                nxt_state   = OS_OFF;
                nxt_cnt     = '0;
                nxt_low_len = '0;
                nxt_acc     = '0;
            end else begin
                nxt_state   = OS_HIGH;
                nxt_cnt     = hi_len - 1'b1;
                nxt_low_len = half;
                nxt_acc     = sum[FP_W-1:0];
                nxt_first   = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= OS_OFF;
            cnt     <= '0;
            low_len <= '0;
            acc     <= '0;
            first   <= 1'b0;
        end else begin
            state   <= nxt_state;
            cnt     <= nxt_cnt;
            low_len <= nxt_low_len;
            acc     <= nxt_acc;
            first   <= nxt_first;
        end
    end

    // Outputs
    always_comb begin
        os_clk  = (state == OS_HIGH);
        os_tick = first;
        running = (state != OS_OFF);
    end

    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OS_OFF) |-> (!os_tick && !os_clk));
    a_r5_tick_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> os_clk);
    a_r5_rise_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(os_clk) |-> os_tick);
    a_r5_high_balanced: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OS_HIGH) |-> ({1'b0, cnt} <= {1'b0, low_len} + 1'b1));
    a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OS_HIGH && cnt != '0) |=> $stable(low_len));
endmodule

// File: rtl/fbg_rate_div.sv
module fbg_rate_div
    import fbg_pkg::*;
#(
    parameter int FIDI_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              os_tick,
    input  line_mode_e        mode,
    input  logic              over_sel,
    input  logic [FIDI_W-1:0] fidi,
    output logic              bit_tick
);
    localparam logic [FIDI_W-1:0] OS16 = FIDI_W'(16);
    localparam logic [FIDI_W-1:0] OS8  = FIDI_W'(8);
    localparam logic [FIDI_W-1:0] OS1  = FIDI_W'(1);

    rt_state_e         state, nxt_state;
    logic [FIDI_W-1:0] rcnt, nxt_rcnt;
    logic [FIDI_W-1:0] target;
    logic              enable;
    logic              wrap;

    always_comb begin
        unique case (mode)
            MODE_ASYNC:          target = over_sel ? OS8 : OS16;
            MODE_SYNC, MODE_SPI: target = OS1;
            MODE_CARD:           target = fidi;
            default:             target = OS16;
        endcase
        enable = running && (target != '0);
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_rcnt  = rcnt;
        wrap      = 1'b0;
        unique case (state)
            RT_IDLE: begin
                nxt_rcnt = '0;
                if (enable) begin
                    nxt_state = RT_COUNT;
                    if (os_tick) begin
                        if (target == OS1) wrap = 1'b1;
                        else nxt_rcnt = FIDI_W'(1);
                    end
                end
            end
            RT_COUNT: begin
                if (!enable) begin
                    nxt_state = RT_IDLE;
                    nxt_rcnt  = '0;
                end else if (os_tick) begin
                    if (rcnt >= target - 1'b1) begin
                        wrap     = 1'b1;
                        nxt_rcnt = '0;
                    end else begin
                        nxt_rcnt = rcnt + 1'b1;
                    end
                end
            end
            default: begin
                nxt_state = RT_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RT_IDLE;
            rcnt  <= '0;
        end else begin
            state <= nxt_state;
            rcnt  <= nxt_rcnt;
        end
    end

    // Outputs
    always_comb begin
        bit_tick = wrap;
    end

    a_r7_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    a_r8_sync_every: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SYNC || mode == MODE_SPI) && os_tick) |-> bit_tick);
    a_r9_card_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CARD && fidi == '0) |-> !bit_tick);
    a_r3_stopped_no_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !bit_tick);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int CD_W   = fbg_pkg::CD_W,
    parameter int FP_W   = fbg_pkg::FP_W,
    parameter int FIDI_W = fbg_pkg::FIDI_W,
    parameter int REG_W  = fbg_pkg::REG_W,
    parameter int FP_LSB = fbg_pkg::FP_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_prot,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [1:0]        line_mode,
    input  logic              over_sel,
    input  logic [FIDI_W-1:0] fidi_ratio,
    output logic              os_tick,
    output logic              os_clk,
    output logic              bit_tick
);
    logic [CD_W-1:0] cfg_cd;
    logic [FP_W-1:0] cfg_fp;
    logic            running;

    fbg_cfg_reg #(
        .CD_W(CD_W), .FP_W(FP_W), .FP_LSB(FP_LSB), .REG_W(REG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_prot(wr_prot),
        .wr_data(wr_data), .cfg_cd(cfg_cd), .cfg_fp(cfg_fp), .rd_data(rd_data)
    );

    fbg_frac_div #(
        .CD_W(CD_W), .FP_W(FP_W)
    ) u_frac (
        .clk(clk), .rst_n(rst_n), .cfg_cd(cfg_cd), .cfg_fp(cfg_fp),
        .os_tick(os_tick), .os_clk(os_clk), .running(running)
    );

    fbg_rate_div #(
        .FIDI_W(FIDI_W)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .running(running), .os_tick(os_tick),
        .mode(line_mode_e'(line_mode)), .over_sel(over_sel), .fidi(fidi_ratio),
        .bit_tick(bit_tick)
    );
endmodule

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_prot = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  line_mode = 2'b01;
    logic        over_sel = 1'b0;
    logic [10:0] fidi_ratio = 11'd1;
    logic        os_tick, os_clk, bit_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_prot(wr_prot),
        .wr_data(wr_data), .rd_data(rd_data), .line_mode(line_mode),
        .over_sel(over_sel), .fidi_ratio(fidi_ratio),
        .os_tick(os_tick), .os_clk(os_clk), .bit_tick(bit_tick)
    );

    function automatic int per_bit(input int mode, input int ov, input int fd);
        if (mode == 0) return ov ? 8 : 16;
        if (mode == 3) return fd;
        return 1;
    endfunction

    function automatic int span8(input int cd, input int fp, input int r);
        return r * (8 * cd + fp);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_os(input int k);
        int n = 0;
        int c = 0;
        while (n < k && c < 150000) begin
            @(negedge clk); c++;
            if (os_tick) n++;
        end
    endtask

    // Cycles spanned by k ticks after an aligning tick
    task automatic span(input bit use_bit, input int k, output int cyc);
        int c = 0;
        int n = 0;
        while (!(use_bit ? bit_tick : os_tick) && c < 100000) begin
            @(negedge clk); c++;
        end
        c = 0;
        while (n < k && c < 150000) begin
            @(negedge clk); c++;
            if (use_bit ? bit_tick : os_tick) n++;
        end
        cyc = c;
    endtask

    // High-phase clocks over k oversampling periods
    task automatic high_count(input int k, output int hi);
        int n = 0;
        int c = 0;
        while (!os_tick && c < 100000) begin
            @(negedge clk); c++;
        end
        hi = 1;
        c = 0;
        while (n < k && c < 100000) begin
            @(negedge clk); c++;
            if (os_tick) n++;
            if (n < k && os_clk) hi++;
        end
    endtask

    task automatic gap_next(output int g);
        int c = 0;
        do begin
            @(negedge clk); c++;
        end while (!os_tick && c < 100000);
        g = c;
    endtask

    initial begin
        #(8ns * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc, hi, g, cnt, seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset rd_data", rd_data, 0);
        check("R1 reset os_tick", os_tick, 0);
        check("R1 reset os_clk", os_clk, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 idle os_clk", os_clk, 0);

        // R1 field layout and masking
        wr(32'hABC5_0009);
        check("R1 readback", rd_data, 32'h0005_0009);
        line_mode = 2'b01;
        wait_os(3);
        span(1'b0, 8, cyc);
        check("R4 span cd9 fp5", cyc, span8(9, 5, 1));

        // R2 protected write ignored
        wr_prot = 1'b1;
        wr(32'h0000_0003);
        wr_prot = 1'b0;
        check("R2 readback kept", rd_data, 32'h0005_0009);
        wait_os(3);
        span(1'b0, 8, cyc);
        check("R2 timing kept", cyc, span8(9, 5, 1));

        // R5 duty cycle
        wr(32'h0000_0005);
        wait_os(3);
        high_count(8, hi);
        check("R5 high cd5 fp0", hi, 24);
        wr(32'h0003_0006);
        wait_os(3);
        high_count(8, hi);
        check("R5 high cd6 fp3", hi, 27);

        // R7 directed oversampling ratios
        line_mode = 2'b00; over_sel = 1'b1;
        wr(32'h0000_0001);
        wait_os(3);
        span(1'b1, 8, cyc);
        check("R7 8x cd1", cyc, 64);
        over_sel = 1'b0;
        span(1'b1, 1, cyc);
        span(1'b1, 8, cyc);
        check("R7 16x cd1", cyc, 128);

        // R9 ratio zero gives no bit ticks
        line_mode = 2'b11; fidi_ratio = 11'd0;
        wr(32'h0000_0002);
        wait_os(3);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (bit_tick) seen++;
        end
        check("R9 fidi zero", seen, 0);

        // R6 write captured on the boundary edge: one more old period
        line_mode = 2'b01;
        wr(32'h0000_0006);
        wait_os(3);
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_0003;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 boundary tick", os_tick, 1);
        gap_next(g);
        check("R6 old period kept", g, 6);
        gap_next(g);
        check("R6 new period", g, 3);

        // R6 write one edge before the boundary: new value at once
        wr(32'h0000_0006);
        wait_os(3);
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_0003;
        @(negedge clk);
        wr_en = 1'b0;
        gap_next(g);
        check("R6 early reach boundary", g, 1);
        gap_next(g);
        check("R6 early new period", g, 3);

        // R3 divisor zero stops everything
        wr(32'h0007_0000);
        repeat (20) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (os_tick || os_clk || bit_tick) cnt++;
        end
        check("R3 disabled activity", cnt, 0);

        // Random settings across modes (R4, R7, R8, R9)
        void'($urandom(32'd1234));
        for (int t = 0; t < 14; t++) begin
            int cd, fp, md, ov, fd;
            cd = 1 + int'($urandom % 20);
            fp = int'($urandom % 8);
            md = int'($urandom % 4);
            ov = int'($urandom % 2);
            fd = 1 + int'($urandom % 12);
            line_mode = md[1:0]; over_sel = ov[0]; fidi_ratio = fd[10:0];
            wr({13'd0, fp[2:0], cd[15:0]});
            wait_os(3);
            span(1'b0, 8, cyc);
            check("R4 random os span", cyc, span8(cd, fp, 1));
            span(1'b1, 8, cyc);
            if (md == 0)      check("R7 random async", cyc, span8(cd, fp, per_bit(md, ov, fd)));
            else if (md == 3) check("R9 random card", cyc, span8(cd, fp, per_bit(md, ov, fd)));
            else              check("R8 random sync/spi", cyc, span8(cd, fp, per_bit(md, ov, fd)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule